// File: doc/BRIEF.md
# H-Bridge PWM Output Steering

This block generates pulse-width modulated drive for motor and gauge coils and steers each waveform onto one of two pins. Channels are grouped in pairs. Channel `2n` uses the pair's first pin pair (C0), and channel `2n+1` uses its second pin pair (C1). Every pin has a data output and an output-enable. A single up-counter sets the PWM period for all channels. Each channel compares that count against its own duty magnitude.

Each channel has a 2-bit output mode:
- **Off:** both pins are released.
- **Half bridge:** PWM appears on the plus pin only, and the minus pin is released for other logic.
- **Full bridge:** the sign bit of the duty word picks the pin that carries PWM. The other pin holds a static level set by a global recirculation input.
- **Dual bridge:** the two channels of a pair act as one coherent unit.

Duty and sign are buffered. They take effect only at the counter wrap, so a period is never cut short and the pins never swap in mid-period.

Top module: `hbridge_pwm_steer`

## Requirements
- R1: A synchronous active-high reset clears the counter and the buffered duty words. From the first clock edge after reset, every data output and every output-enable is 0.
- R2: The shared counter runs from 0 to `period_lim` and then returns to 0, which gives a period of `period_lim`+1 clocks. A channel's raw PWM is high while the count is below its duty magnitude. In each period it is high for min(magnitude, `period_lim`+1) clocks.
- R3: The duty word is 12 bits wide. Bit 4 is the sign. The 11-bit magnitude is bits 11..5 followed by bits 3..0.
- R4: Full-bridge mode is code 2'b10. With sign 0, PWM appears on the plus pin and the minus pin is static. With sign 1, PWM appears on the minus pin and the plus pin is static. Both output-enables are 1.
- R5: In the full-bridge and dual-bridge modes, recirculation 0 holds the static pin low and drives PWM true on the active pin. Recirculation 1 holds the static pin high and inverts the PWM on the active pin.
- R6: Half-bridge mode is code 2'b01. PWM appears true on the plus pin and the plus output-enable is 1. The minus pin's output-enable and data are 0. Sign and recirculation have no effect.
- R7: Off mode is code 2'b00. Both pins of the channel have output-enable 0 and data 0.
- R8: Changes to duty magnitude or sign take effect only when the counter wraps to 0. The period in progress keeps its old duty and its old pin choice.
- R9: Dual-bridge mode is code 2'b11 and steers pins as in R4. A channel in this mode loads a new duty word at a wrap only if its pair partner is also in 2'b11. Otherwise it keeps its previous duty. A channel in full-bridge mode loads at every wrap, whatever its partner's mode.
- R10: Channel k drives bit k of each pin vector, where k = 2n for the pair's C0 pins and 2n+1 for its C1 pins. One channel's settings do not affect another channel's pins, except through R9.
- R11: Pin outputs are registered. A mode change shows at the pins one clock after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_lim | input | CNT_W | Last count value of the period |
| recirc | input | 1 | Global static level for the non-PWM pin in full-bridge modes |
| mode_i | input | 2*NCH | 2-bit output mode per channel, channel k at bits 2k+1..2k |
| duty_i | input | (CNT_W+1)*NCH | Duty word per channel (sign plus magnitude), channel k in slice k |
| pin_p_o | output | NCH | Plus pin data per channel |
| pin_p_oe | output | NCH | Plus pin output-enable per channel |
| pin_m_o | output | NCH | Minus pin data per channel |
| pin_m_oe | output | NCH | Minus pin output-enable per channel |

## Verification
The bench builds the block with its default values: 6 pairs (12 channels) and an 11-bit counter. At run time `period_lim` is set to 9 and to 4, so full periods of 10 and 5 clocks can be counted in full.

The short periods make these cases cheap to reach:
- 0% duty.
- Saturated 100% duty, with a magnitude above the period.
- The inverted recirculation polarity.
- A duty or sign change made in mid-period, which must wait for the wrap.

Using all 12 channels exercises the pair-partner rule of the dual mode on both the C0 and C1 positions. It also shows that each channel drives only its own pin bits.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_HALF = 2'b01,
    MODE_FULL = 2'b10,
    MODE_DUAL = 2'b11
  } hb_mode_e;
endpackage

// File: rtl/hb_period_counter.sv
module hb_period_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] lim,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  // A limit lowered below the current count still wraps at once.
  assign wrap = (cnt >= lim);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + CNT_W'(1);
  end

  p_cnt_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt >= lim) |=> (cnt == '0));
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt < lim) |=> (cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: rtl/hb_chan_shadow.sv
module hb_chan_shadow
  import hb_pkg::*;
#(
  parameter int CNT_W    = 11,
  parameter int SIGN_POS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrap,
  input  logic [1:0]       mode,
  input  logic [1:0]       partner_mode,
  input  logic [CNT_W:0]   duty,
  output logic [CNT_W-1:0] mag_q,
  output logic             sign_q
);
  localparam int DUTY_W = CNT_W + 1;

  logic [CNT_W-1:0] mag_n;
  logic             load_ok;

  // Magnitude is the duty word with the sign bit removed.
  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      if (i < SIGN_POS) mag_n[i] = duty[i];
      else              mag_n[i] = duty[i+1];
    end
  end

  // A dual-mode channel loads only when its partner is also in dual mode.
  assign load_ok = (hb_mode_e'(mode) != MODE_DUAL) ||
                   (hb_mode_e'(partner_mode) == MODE_DUAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      mag_q  <= '0;
      sign_q <= 1'b0;
    end else if (wrap && load_ok) begin
      mag_q  <= mag_n;
      sign_q <= duty[SIGN_POS];
    end
  end

  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> ($stable(mag_q) && $stable(sign_q)));
  p_dual_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (wrap && mode == 2'b11 && partner_mode != 2'b11) |=> $stable(mag_q));
  initial begin
    a_sign_pos_r3: assert (SIGN_POS >= 0 && SIGN_POS < DUTY_W);
  end
endmodule

// File: rtl/hb_pin_steer.sv
module hb_pin_steer
  import hb_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] mag,
  input  logic             sign,
  input  logic             recirc,
  output logic             p_o,
  output logic             p_oe,
  output logic             m_o,
  output logic             m_oe
);
  logic pwm_raw, pwm_act;
  logic p_n, pe_n, m_n, me_n;

  assign pwm_raw = (cnt < mag);
  assign pwm_act = pwm_raw ^ recirc;

  always_comb begin
    p_n = 1'b0; pe_n = 1'b0; m_n = 1'b0; me_n = 1'b0;
    unique case (hb_mode_e'(mode))
      MODE_OFF: ;
      MODE_HALF: begin
        p_n  = pwm_raw;
        pe_n = 1'b1;
      end
      MODE_FULL, MODE_DUAL: begin
        pe_n = 1'b1;
        me_n = 1'b1;
        if (sign) begin
          m_n = pwm_act;
          p_n = recirc;
        end else begin
          p_n = pwm_act;
          m_n = recirc;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_o <= 1'b0; p_oe <= 1'b0; m_o <= 1'b0; m_oe <= 1'b0;
    end else begin
      p_o <= p_n; p_oe <= pe_n; m_o <= m_n; m_oe <= me_n;
    end
  end

  p_reset_release_r1: assert property (@(posedge clk)
    rst |=> (!p_oe && !m_oe && !p_o && !m_o));
  p_off_release_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> (!p_oe && !m_oe && !p_o && !m_o));
  p_half_minus_free_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |=> (p_oe && !m_oe && !m_o));
  p_full_drive_r4: assert property (@(posedge clk) disable iff (rst)
    (mode[1]) |=> (p_oe && m_oe));
  p_idle_minus_r5: assert property (@(posedge clk) disable iff (rst)
    (mode[1] && !sign) |=> (m_o == $past(recirc)));
  p_idle_plus_r5: assert property (@(posedge clk) disable iff (rst)
    (mode[1] && sign) |=> (p_o == $past(recirc)));
endmodule

// File: rtl/hbridge_pwm_steer.sv
module hbridge_pwm_steer #(
  parameter int NUM_PAIRS = 6,
  parameter int CNT_W     = 11,
  parameter int SIGN_POS  = 4
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [CNT_W-1:0]                     period_lim,
  input  logic                                 recirc,
  input  logic [2*2*NUM_PAIRS-1:0]             mode_i,
  input  logic [(CNT_W+1)*2*NUM_PAIRS-1:0]     duty_i,
  output logic [2*NUM_PAIRS-1:0]               pin_p_o,
  output logic [2*NUM_PAIRS-1:0]               pin_p_oe,
  output logic [2*NUM_PAIRS-1:0]               pin_m_o,
  output logic [2*NUM_PAIRS-1:0]               pin_m_oe
);
  localparam int NCH    = 2 * NUM_PAIRS;
  localparam int DUTY_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic             wrap;

  hb_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .lim(period_lim), .cnt(cnt), .wrap(wrap)
  );

  for (genvar n = 0; n < NUM_PAIRS; n++) begin : g_pair
    for (genvar c = 0; c < 2; c++) begin : g_chan
      localparam int K  = 2*n + c;
      localparam int PK = 2*n + (1 - c);
      logic [CNT_W-1:0] mag_q;
      logic             sign_q;

      hb_chan_shadow #(.CNT_W(CNT_W), .SIGN_POS(SIGN_POS)) u_shadow (
        .clk(clk), .rst(rst), .wrap(wrap),
        .mode(mode_i[2*K +: 2]), .partner_mode(mode_i[2*PK +: 2]),
        .duty(duty_i[DUTY_W*K +: DUTY_W]),
        .mag_q(mag_q), .sign_q(sign_q)
      );

      hb_pin_steer #(.CNT_W(CNT_W)) u_steer (
        .clk(clk), .rst(rst), .cnt(cnt), .mode(mode_i[2*K +: 2]),
        .mag(mag_q), .sign(sign_q), .recirc(recirc),
        .p_o(pin_p_o[K]), .p_oe(pin_p_oe[K]),
        .m_o(pin_m_o[K]), .m_oe(pin_m_oe[K])
      );
    end
  end

  p_mode_reg_r11: assert property (@(posedge clk) disable iff (rst)
    (mode_i == '0) |=> (pin_p_oe == '0 && pin_m_oe == '0));
  initial begin
    a_width_r10: assert (NCH == $bits(pin_p_o));
  end
endmodule

// File: tb/sim_hbridge_pwm_steer.sv
module sim_hbridge_pwm_steer;
  localparam int NP = 6;
  localparam int NCH = 2*NP;
  localparam int CW = 11;
  localparam int DW = CW + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] period_lim = CW'(9);
  logic recirc = 1'b0;
  logic [2*NCH-1:0] mode_i = '0;
  logic [DW*NCH-1:0] duty_i = '0;
  logic [NCH-1:0] pin_p_o, pin_p_oe, pin_m_o, pin_m_oe;

  int checks = 0;
  int errors = 0;
  int pc[NCH], mc[NCH], pec[NCH], mec[NCH];

  always #2 clk = ~clk;

  hbridge_pwm_steer #(.NUM_PAIRS(NP), .CNT_W(CW), .SIGN_POS(4)) u0 (
    .clk(clk), .rst(rst), .period_lim(period_lim), .recirc(recirc),
    .mode_i(mode_i), .duty_i(duty_i),
    .pin_p_o(pin_p_o), .pin_p_oe(pin_p_oe),
    .pin_m_o(pin_m_o), .pin_m_oe(pin_m_oe)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        sgn;
    logic [10:0] mag;
    logic        rc;
    logic [7:0]  ep, em, epe, eme;
  } vec_t;

  // Period 10 (period_lim = 9): modes 00 off, 01 half, 10 full, 11 dual.
  localparam vec_t TBL [10] = '{
    '{2'b10, 1'b0, 11'd3,  1'b0, 8'd3,  8'd0,  8'd10, 8'd10}, // R4
    '{2'b10, 1'b1, 11'd3,  1'b0, 8'd0,  8'd3,  8'd10, 8'd10}, // R4
    '{2'b10, 1'b0, 11'd3,  1'b1, 8'd7,  8'd10, 8'd10, 8'd10}, // R5
    '{2'b10, 1'b1, 11'd7,  1'b1, 8'd10, 8'd3,  8'd10, 8'd10}, // R5
    '{2'b01, 1'b0, 11'd4,  1'b0, 8'd4,  8'd0,  8'd10, 8'd0},  // R6
    '{2'b01, 1'b1, 11'd4,  1'b1, 8'd4,  8'd0,  8'd10, 8'd0},  // R6
    '{2'b00, 1'b1, 11'd5,  1'b1, 8'd0,  8'd0,  8'd0,  8'd0},  // R7
    '{2'b10, 1'b0, 11'd0,  1'b0, 8'd0,  8'd0,  8'd10, 8'd10}, // R2
    '{2'b10, 1'b0, 11'd15, 1'b0, 8'd10, 8'd0,  8'd10, 8'd10}, // R2
    '{2'b11, 1'b1, 11'd5,  1'b0, 8'd0,  8'd5,  8'd10, 8'd10}  // R9
  };

  // R3: sign at bit 4, magnitude in bits 11..5 then 3..0.
  function automatic logic [DW-1:0] pack(input logic s, input logic [10:0] m);
    return {m[10:4], s, m[3:0]};
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic set_ch(input int k, input logic [1:0] md, input logic s, input logic [10:0] m);
    mode_i[2*k +: 2] = md;
    duty_i[DW*k +: DW] = pack(s, m);
  endtask

  task automatic set_all(input logic [1:0] md, input logic s, input logic [10:0] m);
    for (int k = 0; k < NCH; k++) set_ch(k, md, s, m);
  endtask

  task automatic settle();
    repeat (2*(int'(period_lim)+1) + 3) @(negedge clk);
  endtask

  task automatic window();
    for (int k = 0; k < NCH; k++) begin pc[k]=0; mc[k]=0; pec[k]=0; mec[k]=0; end
    for (int s = 0; s <= int'(period_lim); s++) begin
      @(negedge clk);
      for (int k = 0; k < NCH; k++) begin
        pc[k]  += int'(pin_p_o[k]);  mc[k]  += int'(pin_m_o[k]);
        pec[k] += int'(pin_p_oe[k]); mec[k] += int'(pin_m_oe[k]);
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int sp, sm;
    logic prev;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "p_oe after reset", int'(pin_p_oe), 0);
    chk("R1", "m_oe after reset", int'(pin_m_oe), 0);
    chk("R1", "data after reset", int'(pin_p_o | pin_m_o), 0);
    rst = 1'b0;

    // Vector table, all channels configured alike
    for (int v = 0; v < 10; v++) begin
      set_all(TBL[v].mode, TBL[v].sgn, TBL[v].mag);
      recirc = TBL[v].rc;
      settle();
      window();
      for (int k = 0; k < NCH; k++) begin
        chk($sformatf("R2/R4-R9 vec%0d ch%0d", v, k), "plus highs", pc[k], int'(TBL[v].ep));
        chk($sformatf("R2/R4-R9 vec%0d ch%0d", v, k), "minus highs", mc[k], int'(TBL[v].em));
        chk($sformatf("R4/R6/R7 vec%0d ch%0d", v, k), "plus oe", pec[k], int'(TBL[v].epe));
        chk($sformatf("R4/R6/R7 vec%0d ch%0d", v, k), "minus oe", mec[k], int'(TBL[v].eme));
      end
    end

    // R11: mode change visible one clock later
    recirc = 1'b0;
    set_all(2'b10, 1'b0, 11'd3);
    settle();
    mode_i = '0;
    @(negedge clk);
    chk("R11", "oe one clock after off", int'(pin_p_oe | pin_m_oe), 0);

    // R8: mid-period change waits for wrap
    set_all(2'b10, 1'b0, 11'd5);
    settle();
    prev = pin_p_o[0];
    do begin
      @(negedge clk);
      if (!(prev == 1'b0 && pin_p_o[0] == 1'b1)) prev = pin_p_o[0];
      else break;
    end while (1);
    sp = 1; sm = int'(pin_m_o[0]);
    for (int s = 1; s < 10; s++) begin
      @(negedge clk);
      sp += int'(pin_p_o[0]); sm += int'(pin_m_o[0]);
      if (s == 2) set_all(2'b10, 1'b1, 11'd8);
    end
    chk("R8", "current period plus highs", sp, 5);
    chk("R8", "current period minus highs", sm, 0);
    sp = 0; sm = 0;
    for (int s = 0; s < 10; s++) begin
      @(negedge clk);
      sp += int'(pin_p_o[0]); sm += int'(pin_m_o[0]);
    end
    chk("R8", "next period plus highs", sp, 0);
    chk("R8", "next period minus highs", sm, 8);

    // R9: dual channel holds until partner is dual
    set_all(2'b10, 1'b0, 11'd3);
    settle();
    set_ch(0, 2'b11, 1'b0, 11'd6);
    set_ch(1, 2'b10, 1'b0, 11'd7);
    settle(); window();
    chk("R9", "dual ch0 held", pc[0], 3);
    chk("R9", "full ch1 updated", pc[1], 7);
    set_ch(1, 2'b11, 1'b0, 11'd7);
    settle(); window();
    chk("R9", "dual ch0 loads with partner", pc[0], 6);
    chk("R9", "dual ch1", pc[1], 7);

    // R10: only channel 3 (pair 1, C1) active
    set_all(2'b00, 1'b0, 11'd0);
    set_ch(3, 2'b10, 1'b1, 11'd4);
    settle(); window();
    chk("R10", "ch3 minus highs", mc[3], 4);
    chk("R10", "ch3 plus highs", pc[3], 0);
    chk("R10", "ch3 plus oe", pec[3], 10);
    for (int k = 0; k < NCH; k++)
      if (k != 3) chk($sformatf("R10 ch%0d", k), "idle oe", pec[k] + mec[k], 0);

    // R2: shorter period
    period_lim = CW'(4);
    set_all(2'b10, 1'b0, 11'd2);
    settle(); window();
    chk("R2", "lim4 duty2", pc[5], 2);
    set_all(2'b10, 1'b0, 11'd9);
    settle(); window();
    chk("R2", "lim4 saturated", pc[5], 5);

    // R1: mid-run reset
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "oe after mid-run reset", int'(pin_p_oe | pin_m_oe), 0);
    chk("R1", "data after mid-run reset", int'(pin_p_o | pin_m_o), 0);
    rst = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule